// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Programming Controller

This block is the digital model of the programming side of a one-time-programmable memory organised as 16-bit words. A tester drives a flag that says the programming supply is at high voltage, two flags that say particular address pins sit at high voltage, two active-low strobes (program and verify), an address and a write word. From these the block decodes the operating mode. It burns words into the array or into a hidden configuration word, and it drives the stored word back for verification. With the supply low it also returns a two-word identification code. Cells start at 0 and can only be set to 1, so every program operation ORs the write word into the stored one.

With the programming supply low, the block behaves as an ordinary read-only memory. The address is registered before the array is read, so a word appears two clock edges after its address. With the supply high, that address register is bypassed, so verify data appears one edge after the address. The array depth is a parameter. The default of 1024 words keeps elaboration small, and a value of 14 for the address width gives the full 16K-word part.

Top module: `prog_ctrl`

## Requirements
- R1: With `hv_supply` high and both `pgm_n` and `vfy_n` high (inhibit), one clock edge later `rdata_oe` is 0 and `rdata` is 0.
- R2: Each entry into program mode (`hv_supply` high, `pgm_n` low, `vfy_n` high, `hv_a2` low) performs one program operation: the word at `addr` becomes its old value ORed with `wdata`. Holding the strobe low does not repeat the operation, and a 0 in `wdata` never clears a stored 1.
- R3: In verify mode (`hv_supply` high, `vfy_n` low, `pgm_n` high, `hv_a2` low), one clock edge after an address is applied, `rdata` shows the stored word at that address and `rdata_oe` is 1.
- R4: With `hv_supply` high and both strobes low (illegal), one edge later `illegal` is 1 and `rdata_oe` is 0. No array word and no bit of the configuration word changes.
- R5: After reset the configuration word reads 0, and every array word that has never been programmed reads 0.
- R6: With `hv_a2` high, program and verify act on the single configuration word instead of the array, whatever `addr` holds. The array word at `addr` is left unchanged.
- R7: With `hv_supply` low and `hv_a9` low, the strobes, `hv_a2` and `wdata` have no effect. `rdata` shows the array word whose address was applied two edges earlier, and `rdata_oe` is 1.
- R8: With `hv_supply` low and `hv_a9` high, one edge later `rdata` is 0x0034 if `addr[0]` is 0 and 0x0013 if `addr[0]` is 1, with `rdata_oe` set to 1.
- R9: `illegal` is 0 one edge after any mode other than illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_supply | input | 1 | Programming supply is at high voltage |
| hv_a2 | input | 1 | Configuration-word select pin is at high voltage |
| hv_a9 | input | 1 | Identification-code pin is at high voltage |
| pgm_n | input | 1 | Program strobe, active low |
| vfy_n | input | 1 | Verify strobe, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to program |
| rdata | output | DATA_W | Read, verify or identification data; 0 when not driven |
| rdata_oe | output | 1 | Data bus is driven |
| illegal | output | 1 | Both strobes were low with the supply high |

## Verification
Every array word is programmed with an arithmetic pattern and then ORed with a second pattern whose bits overlap the first. Both results are verified over the full depth, one address per cycle. This separates a true OR from a plain overwrite, and it shows whether the one-edge verify latency holds. The same depth is then swept in normal read mode with a strobe held low. That sweep separates the two-edge registered path from the bypassed one and shows that the strobes are ignored. Further short sequences cover writing zeros over ones, configuration-word programming and its isolation from the array, illegal strobe pairs with a full-ones write word, and both identification codes.

// File: rtl/prog_pkg.sv
package prog_pkg;
  typedef enum logic [2:0] {
    MD_READ, MD_SIG, MD_INHIBIT, MD_PROG, MD_VERIFY, MD_ILLEGAL
  } mode_e;

  typedef enum logic [2:0] {
    SRC_OFF, SRC_ARRAY, SRC_CTRL, SRC_MFR, SRC_DEV
  } src_e;

  localparam logic [15:0] ID_MAKER  = 16'h0034;
  localparam logic [15:0] ID_DEVICE = 16'h0013;
endpackage

// File: rtl/prog_mode_decode.sv
module prog_mode_decode
  import prog_pkg::*;
(
  input  logic  hv_supply,
  input  logic  hv_a9,
  input  logic  pgm_n,
  input  logic  vfy_n,
  output mode_e mode
);
  always_comb begin
    if (!hv_supply)            mode = hv_a9 ? MD_SIG : MD_READ;
    else if (pgm_n && vfy_n)   mode = MD_INHIBIT;
    else if (!pgm_n && vfy_n)  mode = MD_PROG;
    else if (pgm_n && !vfy_n)  mode = MD_VERIFY;
    else                       mode = MD_ILLEGAL;
  end
endmodule

// File: rtl/prog_word_store.sv
module prog_word_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/prog_out_sel.sv
module prog_out_sel
  import prog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  src_e              src,
  input  logic [DATA_W-1:0] array_word,
  input  logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  always_comb begin
    rdata_oe = (src != SRC_OFF);
    unique case (src)
      SRC_ARRAY: rdata = array_word;
      SRC_CTRL:  rdata = ctrl_word;
      SRC_MFR:   rdata = DATA_W'(ID_MAKER);
      SRC_DEV:   rdata = DATA_W'(ID_DEVICE);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/prog_ctrl.sv
module prog_ctrl
  import prog_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_supply,
  input  logic              hv_a2,
  input  logic              hv_a9,
  input  logic              pgm_n,
  input  logic              vfy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              illegal
);
  mode_e             mode;
  mode_e             mode_q;
  src_e              src_d, src_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              burn_start;
  logic              wr_pend;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  prog_mode_decode u_dec (
    .hv_supply (hv_supply),
    .hv_a9     (hv_a9),
    .pgm_n     (pgm_n),
    .vfy_n     (vfy_n),
    .mode      (mode)
  );

  // Supply high bypasses the input address register.
  assign rd_addr    = hv_supply ? addr : addr_q;
  assign burn_start = (mode == MD_PROG) && (mode_q != MD_PROG);

  prog_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_data (ram_q),
    .we      (wr_pend),
    .wr_addr (wa_q),
    .wr_data (ram_q | wd_q)
  );

  always_comb begin
    unique case (mode)
      MD_READ:   src_d = SRC_ARRAY;
      MD_SIG:    src_d = addr[0] ? SRC_DEV : SRC_MFR;
      MD_VERIFY: src_d = hv_a2 ? SRC_CTRL : SRC_ARRAY;
      default:   src_d = SRC_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    addr_q <= addr;
    wa_q   <= addr;
    wd_q   <= wdata;
    if (rst) begin
      mode_q  <= MD_READ;
      src_q   <= SRC_OFF;
      illegal <= 1'b0;
      wr_pend <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      mode_q  <= mode;
      src_q   <= src_d;
      illegal <= (mode == MD_ILLEGAL);
      wr_pend <= burn_start && !hv_a2;
      if (burn_start && hv_a2) ctrl_q <= ctrl_q | wdata;
    end
  end

  prog_out_sel #(.DATA_W(DATA_W)) u_out (
    .src        (src_q),
    .array_word (ram_q),
    .ctrl_word  (ctrl_q),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe)
  );
endmodule

// File: rtl/prog_ctrl_chk.sv
module prog_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hv_supply,
  input logic              hv_a9,
  input logic              pgm_n,
  input logic              vfy_n,
  input logic              addr0,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              illegal,
  input logic [DATA_W-1:0] ctrl_word
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= seen | rst;

  assert_inhibit_quiet_R1: assert property (@(posedge clk) disable iff (rst || !seen)
    (hv_supply && pgm_n && vfy_n) |=> (!rdata_oe && rdata == '0));

  assert_illegal_flag_R4: assert property (@(posedge clk) disable iff (rst || !seen)
    (hv_supply && !pgm_n && !vfy_n) |=> (illegal && !rdata_oe));

  assert_ctrl_only_sets_R2: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(rst) |-> ((ctrl_word & $past(ctrl_word)) == $past(ctrl_word)));

  assert_maker_code_R8: assert property (@(posedge clk) disable iff (rst || !seen)
    (!hv_supply && hv_a9 && !addr0) |=> (rdata_oe && rdata == DATA_W'(16'h0034)));

  assert_read_drives_R7: assert property (@(posedge clk) disable iff (rst || !seen)
    (!hv_supply && !hv_a9) |=> rdata_oe);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst || !seen)
    !(hv_supply && !pgm_n && !vfy_n) |=> !illegal);
endmodule

bind prog_ctrl prog_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hv_supply (hv_supply),
  .hv_a9     (hv_a9),
  .pgm_n     (pgm_n),
  .vfy_n     (vfy_n),
  .addr0     (addr[0]),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe),
  .illegal   (illegal),
  .ctrl_word (ctrl_q)
);

// File: tb/sim_prog_ctrl.sv
module sim_prog_ctrl;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hv_supply = 1'b1, hv_a2 = 1'b0, hv_a9 = 1'b0;
  logic          pgm_n = 1'b1, vfy_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe, illegal;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model [N];
  logic [DW-1:0] ctrl_model = '0;

  always #5 clk = ~clk;

  prog_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .hv_supply(hv_supply), .hv_a2(hv_a2), .hv_a9(hv_a9),
    .pgm_n(pgm_n), .vfy_n(vfy_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .illegal(illegal)
  );

  function automatic logic [DW-1:0] pat_a(int a);
    return 16'(a * 40503) ^ 16'h5A00;
  endfunction
  function automatic logic [DW-1:0] pat_b(int a);
    return 16'(a << 6) ^ 16'h0181;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic burn(int a, logic [DW-1:0] d, logic a2);
    addr = AW'(a); wdata = d; hv_a2 = a2; pgm_n = 1'b0;
    tick(3);
    pgm_n = 1'b1;
    tick(1);
    hv_a2 = 1'b0;
    if (a2) ctrl_model = ctrl_model | d; else model[a] = model[a] | d;
  endtask

  task automatic verify_sweep(string req);
    addr = '0; vfy_n = 1'b0;
    for (int a = 0; a < N; a++) begin
      addr = AW'(a);
      tick(1);
      check(req, {rdata_oe, rdata} == {1'b1, model[a]} ? model[a] : ~model[a], model[a]);
    end
    vfy_n = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    tick(3);
    rst = 1'b0;
    tick(2);
    // R1 R9: inhibit after reset
    check("R1 oe", {15'b0, rdata_oe}, 16'h0);
    check("R1 data", rdata, 16'h0);
    check("R9 flag", {15'b0, illegal}, 16'h0);

    // R5: erased state
    verify_sweep("R5 erased array");
    hv_a2 = 1'b1; vfy_n = 1'b0; tick(1);
    check("R5 erased ctrl", rdata, 16'h0);
    vfy_n = 1'b1; hv_a2 = 1'b0; tick(1);

    // R2 R3: program two overlapping patterns
    for (int a = 0; a < N; a++) burn(a, pat_a(a), 1'b0);
    verify_sweep("R3 first pattern");
    for (int a = 0; a < N; a++) burn(a, pat_b(a), 1'b0);
    verify_sweep("R2 OR pattern");

    // R2: zeros never clear ones
    burn(5, 16'h0000, 1'b0);
    vfy_n = 1'b0; addr = AW'(5); tick(1);
    check("R2 zero write", rdata, pat_a(5) | pat_b(5));
    vfy_n = 1'b1; tick(1);

    // R6: configuration word
    burn(3, 16'h8001, 1'b1);
    burn(3, 16'h1000, 1'b1);
    burn(3, 16'h0000, 1'b1);
    hv_a2 = 1'b1; vfy_n = 1'b0; addr = AW'(3); tick(1);
    check("R6 ctrl verify", rdata, 16'h9001);
    hv_a2 = 1'b0; tick(1);
    check("R6 array untouched", rdata, model[3]);
    vfy_n = 1'b1; tick(1);

    // R4: illegal strobes with all-ones data, array and ctrl
    addr = AW'(7); wdata = 16'hFFFF; pgm_n = 1'b0; vfy_n = 1'b0; tick(1);
    check("R4 flag", {15'b0, illegal}, 16'h1);
    check("R4 oe", {15'b0, rdata_oe}, 16'h0);
    tick(2);
    pgm_n = 1'b1; tick(1);
    check("R4 array kept", rdata, model[7]);
    check("R9 flag clears", {15'b0, illegal}, 16'h0);
    hv_a2 = 1'b1; pgm_n = 1'b0; tick(3);
    pgm_n = 1'b1; tick(1);
    check("R4 ctrl kept", rdata, ctrl_model);
    vfy_n = 1'b1; hv_a2 = 1'b0; tick(1);

    // R7: normal read, strobe and hv_a2 held, two-edge latency
    hv_supply = 1'b0; pgm_n = 1'b0; hv_a2 = 1'b1; wdata = 16'hFFFF;
    addr = '0; tick(1);
    for (int a = 1; a <= N; a++) begin
      addr = AW'(a % N);
      tick(1);
      check("R7 read", rdata_oe ? rdata : ~model[a-1], model[a-1]);
    end
    addr = AW'(9); tick(1);
    check("R7 latency old", rdata, model[0]);
    tick(1);
    check("R7 latency new", rdata, model[9]);
    pgm_n = 1'b1; hv_a2 = 1'b0; hv_supply = 1'b1; tick(1);
    verify_sweep("R7 strobes ignored");

    // R8: identification codes
    hv_supply = 1'b0; hv_a9 = 1'b1; addr = '0; tick(1);
    check("R8 maker", rdata, 16'h0034);
    addr = AW'(1); tick(1);
    check("R8 device", rdata, 16'h0013);
    check("R8 oe", {15'b0, rdata_oe}, 16'h1);
    hv_a9 = 1'b0; hv_supply = 1'b1; tick(1);
    check("R1 inhibit again", {rdata[15:1], rdata_oe}, 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule